// File: doc/BRIEF.md
# MDIO Management Serial Target

This block is the device-side end of the two-wire management bus used between an Ethernet MAC (or any station manager) and its PHY. A slow management clock and a shared bidirectional data line are brought into the system clock domain. Frames are decoded bit by bit on each rising edge of the management clock. Read frames are answered by driving the shared line through an output-enable, and write frames update a bank of thirty-two 16-bit registers.

After reset the port is deaf until it has seen a run of 32 ones on the data line. From then on it takes back-to-back frames separated by a single high idle bit. A malformed frame throws it back into the deaf state. The device address is taken from strap pins at reset, and address zero acts as a broadcast for writes. The register bank is a plain store. Bit 10 of register 0 is brought out as an isolate control, and management traffic carries on while it is set.

Top module: `mdio_target`

## Requirements
- R1: After reset every frame is ignored: no register changes and the line is never driven, until 32 consecutive ones have been sampled on 32 management clock rising edges.
- R2: Once synchronised, a frame is accepted after a single idle (1) bit with no further preamble.
- R3: A frame is start bits 0,1, then opcode bits (1,0 = read, 0,1 = write), then a 5-bit device address and a 5-bit register address, both MSB first; register addresses 0 through 31 are all reachable.
- R4: On a matching read, the line is not driven during the first turnaround bit, is driven 0 for the second, then carries the 16 register bits MSB first, and is released after the last data bit.
- R5: On a matching write, the master supplies turnaround 1,0 and 16 data bits MSB first; the addressed register takes that value and the target never drives the line during the frame.
- R6: A start of 0,0, an opcode of 0,0 or 1,1, or a write turnaround other than 1,0 returns the port to the unsynchronised state of R1, so a fresh 32-one preamble is needed.
- R7: A frame whose device address differs from the target's neither drives the line nor writes a register; address 0 is accepted for writes and ignored for reads.
- R8: `isolate_o` follows bit 10 of register 0 (reset value 0), and reads and writes keep working while it is 1.
- R9: The device address is captured from `phy_addr_strap` while reset is held; later changes of the strap have no effect.
- R10: `mdio_oe` is 0 during and after reset and is never 1 while the port is unsynchronised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the management clock |
| rst | input | 1 | Synchronous active-high reset; strap is captured while high |
| mdc_i | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Sampled value of the shared management data line |
| phy_addr_strap | input | 5 | Device address strap |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line (1 = drive) |
| isolate_o | output | 1 | Isolate control, bit 10 of register 0 |

## Verification
The assertions take for granted that each management clock phase lasts at least three system clocks, so that the synchroniser delay never swallows an edge. They also assume that the master changes the data line only while the management clock is low and releases the line for the whole turnaround and data of a read. The stimulus holds each phase for six system clocks, moves the data line only in the low phase, and models the pull-up by resolving an undriven line to 1. Every frame is sent whole, including the frames meant to be rejected. Run lengths of ones are kept below 32 wherever the port has to stay unsynchronised.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W       = 5;
    localparam int DATA_W       = 16;
    localparam int REG_NUM      = 1 << ADDR_W;
    localparam int PREAMBLE_LEN = 32;
    localparam int CNT_W        = $clog2(PREAMBLE_LEN + 1);
    localparam int ISOLATE_BIT  = 10;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = '0;

    typedef enum logic [3:0] {
        ST_UNSYNC,
        ST_IDLE,
        ST_START,
        ST_OP1,
        ST_OP2,
        ST_PHYAD,
        ST_REGAD,
        ST_TA1,
        ST_TA2,
        ST_DATA
    } mstate_t;

    typedef enum logic [1:0] {
        OP_BAD_LO = 2'b00,
        OP_WRITE  = 2'b01,
        OP_READ   = 2'b10,
        OP_BAD_HI = 2'b11
    } mop_t;

    typedef struct packed {
        logic [ADDR_W-1:0] reg_addr;
        logic [DATA_W-1:0] wdata;
        logic              we;
    } reg_req_t;

    // Writes answer to the own address or broadcast; reads only to own.
    function automatic logic addr_hit(input logic is_wr,
                                      input logic [ADDR_W-1:0] phy,
                                      input logic [ADDR_W-1:0] mine);
        return (phy == mine) || (is_wr && (phy == BCAST_ADDR));
    endfunction

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic mdc_rise,
    output logic mdio_bit
);
    logic [STAGES-1:0] mdc_sh;
    logic [STAGES-1:0] mdio_sh;
    logic              mdc_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_sh   <= '0;
            mdio_sh  <= '1;
            mdc_prev <= 1'b0;
        end else begin
            mdc_sh   <= {mdc_sh[STAGES-2:0], mdc_i};
            mdio_sh  <= {mdio_sh[STAGES-2:0], mdio_i};
            mdc_prev <= mdc_sh[STAGES-1];
        end
    end

    assign mdc_rise = mdc_sh[STAGES-1] & ~mdc_prev;
    assign mdio_bit = mdio_sh[STAGES-1];

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output reg_req_t          req,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PREAMBLE_LEN - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    mstate_t           state;
    logic [CNT_W-1:0]  cnt;
    logic              op_first;
    logic              is_write;
    logic              hit;
    logic [ADDR_W-1:0] phy_sh;
    logic [ADDR_W-1:0] reg_sh;
    logic [DATA_W-1:0] sh;

    assign rd_addr = reg_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_UNSYNC;
            cnt      <= '0;
            op_first <= 1'b0;
            is_write <= 1'b0;
            hit      <= 1'b0;
            phy_sh   <= '0;
            reg_sh   <= '0;
            sh       <= '0;
            req      <= '0;
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b0;
        end else begin
            req.we <= 1'b0;
            if (bit_stb) begin
                unique case (state)
                    ST_UNSYNC: begin
                        if (!bit_in) begin
                            cnt <= '0;
                        end else if (cnt == PRE_LAST) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_IDLE: begin
                        if (!bit_in) state <= ST_START;
                    end
                    ST_START: begin
                        if (bit_in) begin
                            state <= ST_OP1;
                        end else begin
                            cnt   <= '0;
                            state <= ST_UNSYNC;
                        end
                    end
                    ST_OP1: begin
                        op_first <= bit_in;
                        state    <= ST_OP2;
                    end
                    ST_OP2: begin
                        cnt <= '0;
                        unique case (mop_t'({op_first, bit_in}))
                            OP_WRITE: begin
                                is_write <= 1'b1;
                                state    <= ST_PHYAD;
                            end
                            OP_READ: begin
                                is_write <= 1'b0;
                                state    <= ST_PHYAD;
                            end
                            default: state <= ST_UNSYNC;
                        endcase
                    end
                    ST_PHYAD: begin
                        phy_sh <= {phy_sh[ADDR_W-2:0], bit_in};
                        if (cnt == ADDR_LAST) begin
                            cnt   <= '0;
                            state <= ST_REGAD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_REGAD: begin
                        reg_sh <= {reg_sh[ADDR_W-2:0], bit_in};
                        if (cnt == ADDR_LAST) begin
                            cnt   <= '0;
                            hit   <= addr_hit(is_write, phy_sh, my_addr);
                            state <= ST_TA1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_TA1: begin
                        if (is_write && !bit_in) begin
                            state <= ST_UNSYNC;
                        end else begin
                            if (hit && !is_write) begin
                                sh      <= rd_data;
                                mdio_o  <= 1'b0;
                                mdio_oe <= 1'b1;
                            end
                            state <= ST_TA2;
                        end
                    end
                    ST_TA2: begin
                        if (is_write && bit_in) begin
                            state <= ST_UNSYNC;
                        end else begin
                            if (hit && !is_write) begin
                                mdio_o <= sh[DATA_W-1];
                                sh     <= sh << 1;
                            end
                            cnt   <= '0;
                            state <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (is_write) begin
                            sh <= {sh[DATA_W-2:0], bit_in};
                        end else if (hit) begin
                            if (cnt == DATA_LAST) begin
                                mdio_oe <= 1'b0;
                                mdio_o  <= 1'b1;
                            end else begin
                                mdio_o <= sh[DATA_W-1];
                                sh     <= sh << 1;
                            end
                        end
                        if (cnt == DATA_LAST) begin
                            if (is_write && hit) begin
                                req.we       <= 1'b1;
                                req.reg_addr <= reg_sh;
                                req.wdata    <= {sh[DATA_W-2:0], bit_in};
                            end
                            hit   <= 1'b0;
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_UNSYNC;
                endcase
            end
        end
    end

    // R10
    oe_unsync_chk: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> (state != ST_UNSYNC));

    // R4
    oe_ta_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_o);

    // R5
    no_drive_write_chk: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> !is_write);

    // R5
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req.we |=> !req.we);

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              isolate
);
    logic [DATA_W-1:0] regs [REG_NUM];

    for (genvar g = 0; g < REG_NUM; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (req.we && (req.reg_addr == ADDR_W'(g))) begin
                regs[g] <= req.wdata;
            end
        end
    end

    assign rd_data = regs[rd_addr];
    assign isolate = regs[0][ISOLATE_BIT];

    // R8
    isolate_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (req.we && (req.reg_addr == '0)) |=> (isolate == $past(req.wdata[ISOLATE_BIT])));

endmodule

// File: rtl/mdio_target.sv
module mdio_target
    import mdio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mdc_i,
    input  logic       mdio_i,
    input  logic [4:0] phy_addr_strap,
    output logic       mdio_o,
    output logic       mdio_oe,
    output logic       isolate_o
);
    logic              bit_stb;
    logic              bit_val;
    logic [ADDR_W-1:0] my_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    reg_req_t          req;

    always_ff @(posedge clk) begin
        if (rst) my_addr <= phy_addr_strap;
    end

    mdio_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .mdc_i    (mdc_i),
        .mdio_i   (mdio_i),
        .mdc_rise (bit_stb),
        .mdio_bit (bit_val)
    );

    mdio_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (bit_stb),
        .bit_in  (bit_val),
        .my_addr (my_addr),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .req     (req),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    mdio_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .isolate (isolate_o)
    );

    // R9
    addr_latched_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(my_addr));

endmodule

// File: tb/mdio_target_bench.sv
module mdio_target_bench;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mdc = 1'b0;
    logic       m_en = 1'b0;
    logic       m_val = 1'b1;
    logic [4:0] strap = 5'd1;
    logic       mdio_o, mdio_oe, isolate_o;
    logic       line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] exp_q[$];
    logic [15:0] got_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    assign line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

    mdio_target u_mdio_target (
        .clk            (clk),
        .rst            (rst),
        .mdc_i          (mdc),
        .mdio_i         (line),
        .phy_addr_strap (strap),
        .mdio_o         (mdio_o),
        .mdio_oe        (mdio_oe),
        .isolate_o      (isolate_o)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compares each finished read with the queued expectation.
    initial begin
        forever begin
            wait (got_q.size() != 0);
            begin
                logic [15:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(g == e, t, g, e);
            end
        end
    end

    task automatic mbit(input logic drv, input logic b, output logic seen, output logic oe_seen);
        @(negedge clk);
        m_en  = drv;
        m_val = b;
        repeat (HALF) @(negedge clk);
        seen    = line;
        oe_seen = mdio_oe;
        mdc     = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic send_bits(input int n, input logic b);
        logic s, o;
        for (int i = 0; i < n; i++) mbit(1'b1, b, s, o);
    endtask

    task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [1:0] ta, input logic [15:0] wd,
                         output logic [15:0] rdata, output logic ta1_line,
                         output logic ta1_oe, output logic ta2_line, output logic any_oe);
        logic s, o;
        logic rd;
        rd = (op == 2'b10);
        any_oe = 1'b0;
        mbit(1'b1, 1'b1, s, o);
        mbit(1'b1, 1'b0, s, o);
        mbit(1'b1, 1'b1, s, o);
        for (int i = 1; i >= 0; i--) begin mbit(1'b1, op[i], s, o); any_oe |= o; end
        for (int i = 4; i >= 0; i--) begin mbit(1'b1, pa[i], s, o); any_oe |= o; end
        for (int i = 4; i >= 0; i--) begin mbit(1'b1, ra[i], s, o); any_oe |= o; end
        mbit(!rd, ta[1], ta1_line, ta1_oe);
        any_oe |= ta1_oe;
        mbit(!rd, ta[0], ta2_line, o);
        any_oe |= o;
        for (int i = 15; i >= 0; i--) begin
            mbit(!rd, wd[i], s, o);
            rdata[i] = s;
            any_oe |= o;
        end
        @(negedge clk);
        m_en  = 1'b1;
        m_val = 1'b1;
    endtask

    task automatic do_write(input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] d, input logic [1:0] ta, input string tag);
        logic [15:0] r;
        logic t1, t1o, t2, ao;
        frame(2'b01, pa, ra, ta, d, r, t1, t1o, t2, ao);
        check(!ao, tag, {15'd0, ao}, 16'd0);
    endtask

    task automatic do_read(input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] exp, input bit hit, input string tag);
        logic [15:0] r;
        logic t1, t1o, t2, ao;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        frame(2'b10, pa, ra, 2'b11, 16'h0000, r, t1, t1o, t2, ao);
        got_q.push_back(r);
        // R4: first turnaround bit undriven, second 0 only on a hit
        check(!t1o && t1, "R4 ta1", {14'd0, t1o, t1}, 16'd1);
        check(t2 == !hit, "R4 ta2", {15'd0, t2}, {15'd0, !hit});
        check(!mdio_oe, "R4 release", {15'd0, mdio_oe}, 16'd0);
    endtask

    task automatic bad_frame(input logic [1:0] op, input logic [1:0] ta) ;
        logic [15:0] r;
        logic t1, t1o, t2, ao;
        frame(op, 5'd1, 5'd5, ta, 16'h0000, r, t1, t1o, t2, ao);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        strap = 5'd3;
        m_en  = 1'b1;
        @(negedge clk);
        // R10 reset state, R8 reset value
        check(!mdio_oe, "R10 reset oe", {15'd0, mdio_oe}, 16'd0);
        check(!isolate_o, "R8 reset isolate", {15'd0, isolate_o}, 16'd0);

        // R1: frames before preamble ignored
        do_write(5'd1, 5'd0, 16'h0400, 2'b10, "R1 write before sync");
        check(!isolate_o, "R1 isolate unchanged", {15'd0, isolate_o}, 16'd0);
        do_read(5'd1, 5'd0, 16'hFFFF, 1'b0, "R1 read before sync");

        send_bits(32, 1'b1);
        // R2 R3 R5: write then read with one idle bit between
        do_write(5'd1, 5'd5, 16'hA5C3, 2'b10, "R5 no drive on write");
        do_read(5'd1, 5'd5, 16'hA5C3, 1'b1, "R2 R3 R5 read back reg5");
        // R9: strap change after reset has no effect
        do_read(5'd3, 5'd5, 16'hFFFF, 1'b0, "R9 later strap ignored");

        // R8 isolate with management still working
        do_write(5'd1, 5'd0, 16'h0400, 2'b10, "R8 write reg0");
        check(isolate_o, "R8 isolate set", {15'd0, isolate_o}, 16'd1);
        do_read(5'd1, 5'd5, 16'hA5C3, 1'b1, "R8 read while isolated");

        // R7 address mismatch and broadcast
        do_write(5'd7, 5'd5, 16'h1111, 2'b10, "R7 foreign write");
        do_read(5'd1, 5'd5, 16'hA5C3, 1'b1, "R7 foreign write ignored");
        do_read(5'd7, 5'd5, 16'hFFFF, 1'b0, "R7 foreign read undriven");
        do_write(5'd0, 5'd6, 16'h3C3C, 2'b10, "R7 broadcast write");
        do_read(5'd1, 5'd6, 16'h3C3C, 1'b1, "R7 broadcast write taken");
        do_read(5'd0, 5'd6, 16'hFFFF, 1'b0, "R7 broadcast read ignored");

        // R3 top register address
        do_write(5'd1, 5'd31, 16'h8001, 2'b10, "R3 write reg31");
        do_read(5'd1, 5'd31, 16'h8001, 1'b1, "R3 read reg31");

        // R6 invalid start 0,0
        send_bits(1, 1'b1);
        send_bits(2, 1'b0);
        do_read(5'd1, 5'd5, 16'hFFFF, 1'b0, "R6 bad start desync");
        send_bits(32, 1'b1);
        do_read(5'd1, 5'd5, 16'hA5C3, 1'b1, "R6 resync after start");

        // R6 invalid opcode 1,1 then write ignored
        bad_frame(2'b11, 2'b10);
        do_write(5'd1, 5'd5, 16'h0F0F, 2'b10, "R6 write after bad op");
        send_bits(32, 1'b1);
        do_read(5'd1, 5'd5, 16'hA5C3, 1'b1, "R6 opcode 11 desync");

        // R6 invalid opcode 0,0
        bad_frame(2'b00, 2'b10);
        do_read(5'd1, 5'd5, 16'hFFFF, 1'b0, "R6 opcode 00 desync");
        send_bits(32, 1'b1);

        // R6 wrong write turnaround
        do_write(5'd1, 5'd6, 16'h0000, 2'b11, "R6 bad ta no drive");
        do_read(5'd1, 5'd6, 16'hFFFF, 1'b0, "R6 bad ta desync");
        send_bits(32, 1'b1);
        do_read(5'd1, 5'd6, 16'h3C3C, 1'b1, "R6 bad ta write dropped");

        // R8 clear isolate
        do_write(5'd1, 5'd0, 16'h0000, 2'b10, "R8 write reg0 clear");
        check(!isolate_o, "R8 isolate cleared", {15'd0, isolate_o}, 16'd0);

        wait (got_q.size() == 0);
        repeat (5) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule